// File: doc/BRIEF.md
# EDO DRAM Data-Pin Drive Controller

This block sits on the device side of an extended-data-out DRAM and decides, clock by clock, whether the four data pins are driven or left floating. A fast system clock samples the four active-low strobes: row strobe, column strobe, write enable and output enable. From them the block produces a registered pin-drive enable and a one-clock write-capture strobe. Read data stays on the pins after the column strobe rises, so a controller can still latch it. Drive is withdrawn only by the output-enable and write-enable sequences listed below. Each of those sequences is latched until the column strobe next falls.

The minimum output-enable hold after the column strobe rises and the minimum output-enable pulse width are clock-count parameters. A strobe sampled at a clock edge affects the outputs right after that same edge. An optional synchronizer depth, `SYNC_STAGES`, adds a fixed number of clocks in front of the whole path.

Top module: `edo_dq_drive_ctrl`

## Requirements
- R1: With the row strobe low and write enable high, a falling column strobe opens a read access. If output enable is low, `dq_oe` is high after that clock edge and stays high when the column strobe rises again.
- R2: `dq_oe` is high only while a read access is open, output enable is sampled low and write enable is sampled high.
- R3: Output enable may already be high in the sample where the column strobe rises. If it then stays high for `OE_HOLD` consecutive samples, counting that rise sample, drive is released and stays off until the next column-strobe fall, even after output enable returns low.
- R4: If that output-enable hold is shorter than `OE_HOLD` samples, a return of output enable to low drives the pins again.
- R5: Output enable may instead be low at the column-strobe rise. A high pulse of at least `OE_PULSE` samples while the column strobe is high then releases drive until the next column-strobe fall. A shorter pulse leaves the pins driven once output enable returns low.
- R6: Write enable may be sampled low in the same sample as the column-strobe fall (early write). Then `dq_oe` stays low until the next column-strobe fall, even if write enable returns high and output enable is low.
- R7: Write enable sampled low while the column strobe is high during a read access releases drive. The release holds until the next column-strobe fall.
- R8: A column-strobe fall clears any latched release. A new read access then drives again.
- R9: A sample with both row and column strobes high closes the access. `dq_oe` goes low and every latched release is cleared.
- R10: While the row strobe is low, `wr_strobe` pulses high for exactly one clock after whichever falls later, the column strobe or write enable. When both fall in the same sample there is one pulse.
- R11: With the column strobe held low after a read, the row strobe may toggle (hidden refresh) and `dq_oe` stays high.
- R12: A column-strobe fall while the row strobe is high (refresh ordering) opens no read access, and `dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_oe | output | 1 | Data-pin drive enable, registered |
| wr_strobe | output | 1 | One-clock write-data capture pulse |

## Verification
A release latch that is stuck set shows up as `dq_oe` staying low after the next column-strobe fall, one clock later. One that fails to set shows up as `dq_oe` rising again in the first sample where output enable returns low during column-strobe high time. An hold/pulse counter that is off by one flips the outcome of a pulse exactly `OE_HOLD-1` or `OE_PULSE-1` samples long. A bad access flag shows up as drive during early writes or refresh orderings, in the clock right after the column strobe falls.

// File: rtl/edo_drv_pkg.sv
package edo_drv_pkg;

   // Sampled strobe bundle, all active low
   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic oe_n;
   } edo_strb_t;

   localparam edo_strb_t STRB_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler
   import edo_drv_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  edo_strb_t raw,
   output edo_strb_t smp,
   output logic      cas_fall,
   output logic      cas_rise,
   output logic      we_fall
);

   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..3");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign smp = raw;
   end else begin : g_sync
      edo_strb_t chain [SYNC_STAGES];
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= STRB_IDLE;
            else if (i == 0) chain[i] <= raw;
            else chain[i] <= chain[(i == 0) ? 0 : i - 1];
         end
      end
      assign smp = chain[SYNC_STAGES-1];
   end

   edo_strb_t prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= STRB_IDLE;
      else        prev_q <= smp;
   end

   assign cas_fall = prev_q.cas_n & ~smp.cas_n;
   assign cas_rise = ~prev_q.cas_n & smp.cas_n;
   assign we_fall  = prev_q.we_n & ~smp.we_n;

endmodule

// File: rtl/edo_oe_release.sv
module edo_oe_release
   import edo_drv_pkg::*;
#(
   parameter int unsigned OE_HOLD  = 2,
   parameter int unsigned OE_PULSE = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  edo_strb_t smp,
   input  logic      cas_fall,
   input  logic      cas_rise,
   output logic      rel_nx,
   output logic      rel_q
);

   localparam int unsigned CNT_MAX = max2(OE_HOLD, OE_PULSE);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] HOLD_T  = CNT_W'(OE_HOLD);
   localparam logic [CNT_W-1:0] PULSE_T = CNT_W'(OE_PULSE);
   localparam logic [CNT_W-1:0] SAT     = CNT_W'(CNT_MAX);

   if (OE_HOLD < 1) begin : g_bad_hold
      $error("OE_HOLD must be at least 1");
   end
   if (OE_PULSE < 1) begin : g_bad_pulse
      $error("OE_PULSE must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic             run_q, run_nx;
   logic             oe_hi, cas_hi, closing;
   logic [CNT_W-1:0] thr;

   assign oe_hi   = smp.oe_n;
   assign cas_hi  = smp.cas_n;
   assign closing = smp.ras_n & smp.cas_n;

   // run_nx: the current output-enable-high run began at the column rise
   always_comb begin
      if (cas_rise)            run_nx = oe_hi;
      else if (!oe_hi || !cas_hi) run_nx = 1'b0;
      else                     run_nx = run_q;
   end

   always_comb begin
      if (cas_hi && oe_hi) cnt_nx = (cnt_q == SAT) ? SAT : cnt_q + 1'b1;
      else                 cnt_nx = '0;
   end

   assign thr = run_nx ? HOLD_T : PULSE_T;

   always_comb begin
      if (closing)                                rel_nx = 1'b0;
      else if (cas_fall)                          rel_nx = 1'b0;
      else if (cas_hi && oe_hi && cnt_nx >= thr)  rel_nx = 1'b1;
      else if (cas_hi && !smp.we_n)               rel_nx = 1'b1;
      else                                        rel_nx = rel_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         rel_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nx;
         run_q <= run_nx;
         rel_q <= rel_nx;
      end
   end

   assert_fall_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cas_fall |=> !rel_q);

   assert_close_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> !rel_q);

endmodule

// File: rtl/edo_write_strobe.sv
module edo_write_strobe
   import edo_drv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  edo_strb_t smp,
   input  logic      cas_fall,
   input  logic      we_fall,
   output logic      wr_q
);

   logic wr_nx;

   assign wr_nx = ~smp.ras_n & ~smp.cas_n & ~smp.we_n & (cas_fall | we_fall);

   always_ff @(posedge clk) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= wr_nx;
   end

   assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q);

endmodule

// File: rtl/edo_dq_drive_ctrl.sv
module edo_dq_drive_ctrl
   import edo_drv_pkg::*;
#(
   parameter int unsigned OE_HOLD     = 2,
   parameter int unsigned OE_PULSE    = 2,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic oe_n,
   output logic dq_oe,
   output logic wr_strobe
);

   edo_strb_t raw, smp;
   logic      cas_fall, cas_rise, we_fall;
   logic      rel_nx, rel_q;
   logic      rd_q, rd_nx;
   logic      drv_nx;

   assign raw = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};

   edo_strobe_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw),
      .smp      (smp),
      .cas_fall (cas_fall),
      .cas_rise (cas_rise),
      .we_fall  (we_fall)
   );

   edo_oe_release #(.OE_HOLD(OE_HOLD), .OE_PULSE(OE_PULSE)) u_rel (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .cas_fall (cas_fall),
      .cas_rise (cas_rise),
      .rel_nx   (rel_nx),
      .rel_q    (rel_q)
   );

   edo_write_strobe u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .cas_fall (cas_fall),
      .we_fall  (we_fall),
      .wr_q     (wr_strobe)
   );

   // Read access: opened by a column fall with row low and write high
   always_comb begin
      if (smp.ras_n && smp.cas_n) rd_nx = 1'b0;
      else if (cas_fall)          rd_nx = ~smp.ras_n & smp.we_n;
      else                        rd_nx = rd_q;
   end

   assign drv_nx = rd_nx & ~rel_nx & ~smp.oe_n & smp.we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         dq_oe <= 1'b0;
      end else begin
         rd_q  <= rd_nx;
         dq_oe <= drv_nx;
      end
   end

   assert_drive_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!smp.oe_n && smp.we_n));

   assert_close_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp.ras_n && smp.cas_n) |=> !dq_oe);

   assert_early_write_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_fall && !smp.we_n) |=> !dq_oe);

   assert_refresh_order_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_fall && smp.ras_n) |=> !dq_oe);

endmodule

// File: tb/test_edo_dq_drive_ctrl.sv
`timescale 1ns/1ps
module test_edo_dq_drive_ctrl;

   localparam int HOLD  = 2;
   localparam int PULSE = 3;
   localparam time TCK  = 8ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic dq_oe, wr_strobe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state kept by the bench
   bit m_pcas = 1, m_pwe = 1;
   bit m_rd = 0, m_rel = 0, m_run = 0;
   int m_cnt = 0;
   bit e_oe = 0, e_wr = 0;

   always #(TCK/2) clk = ~clk;

   edo_dq_drive_ctrl #(.OE_HOLD(HOLD), .OE_PULSE(PULSE)) i_edo_dq_drive_ctrl (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .wr_strobe(wr_strobe)
   );

   task automatic chk(input bit act, input bit exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // expected next state from the requirements, applied per sample
   task automatic model_step();
      bit cf, wf, cr, close;
      int thr;
      cf = m_pcas & ~cas_n;
      cr = ~m_pcas & cas_n;
      wf = m_pwe & ~we_n;
      close = ras_n & cas_n;
      if (close) m_rd = 0;                         // R9
      else if (cf) m_rd = ~ras_n & we_n;           // R1 R6 R12
      if (cr) m_run = oe_n;
      else if (!oe_n || !cas_n) m_run = 0;
      m_cnt = (cas_n && oe_n) ? m_cnt + 1 : 0;
      thr = m_run ? HOLD : PULSE;                  // R3 R5
      if (close) m_rel = 0;
      else if (cf) m_rel = 0;                      // R8
      else if (cas_n && oe_n && m_cnt >= thr) m_rel = 1;
      else if (cas_n && !we_n) m_rel = 1;          // R7
      e_oe = m_rd & ~m_rel & ~oe_n & we_n;         // R2
      e_wr = ~ras_n & ~cas_n & ~we_n & (cf | wf);  // R10
      m_pcas = cas_n;
      m_pwe = we_n;
   endtask

   task automatic cyc(input bit r, input bit c, input bit w, input bit o, input string tag);
      ras_n = r; cas_n = c; we_n = w; oe_n = o;
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(dq_oe, e_oe, {tag, " dq_oe"});
      chk(wr_strobe, e_wr, {tag, " wr_strobe"});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(dq_oe, 1'b0, "reset R2 dq_oe");
      chk(wr_strobe, 1'b0, "reset R10 wr_strobe");
      rst_n = 1'b1;

      // R1 read and extended hold past column rise
      cyc(1,1,1,1, "idle");
      cyc(0,1,1,1, "R1 row");
      cyc(0,0,1,0, "R1 read");  chk(dq_oe, 1'b1, "R1 drive");
      cyc(0,1,1,0, "R1 rise");  chk(dq_oe, 1'b1, "R1 extended hold");
      // R5 short then long pulse
      cyc(0,1,1,1, "R5 p1"); cyc(0,1,1,1, "R5 p2");
      cyc(0,1,1,0, "R5 short"); chk(dq_oe, 1'b1, "R5 short pulse keeps drive");
      cyc(0,1,1,1, "R5 q1"); cyc(0,1,1,1, "R5 q2"); cyc(0,1,1,1, "R5 q3");
      cyc(0,1,1,0, "R5 long"); chk(dq_oe, 1'b0, "R5 long pulse releases");
      // R8 next fall clears
      cyc(0,0,1,0, "R8 fall"); chk(dq_oe, 1'b1, "R8 redrive");
      // R3 hold reaching the count
      cyc(0,0,1,1, "R3 oe up");
      cyc(0,1,1,1, "R3 rise"); cyc(0,1,1,1, "R3 hold2");
      cyc(0,1,1,0, "R3 oe low"); chk(dq_oe, 1'b0, "R3 latched release");
      // R4 hold too short
      cyc(0,0,1,0, "R4 fall"); chk(dq_oe, 1'b1, "R4 drive");
      cyc(0,0,1,1, "R4 oe up");
      cyc(0,1,1,1, "R4 rise");
      cyc(0,1,1,0, "R4 oe low"); chk(dq_oe, 1'b1, "R4 short hold redrives");
      // R7 write low during column-high read time
      cyc(0,1,0,0, "R7 we low"); chk(dq_oe, 1'b0, "R7 off");
      cyc(0,1,1,0, "R7 we high"); chk(dq_oe, 1'b0, "R7 latched");
      cyc(0,0,1,0, "R8 fall2"); chk(dq_oe, 1'b1, "R8 redrive after R7");
      // R11 hidden refresh
      cyc(1,0,1,0, "R11 row up"); chk(dq_oe, 1'b1, "R11 row high");
      cyc(0,0,1,0, "R11 row dn");
      cyc(1,0,1,0, "R11 row up2"); chk(dq_oe, 1'b1, "R11 kept");
      // R9 close
      cyc(1,1,1,0, "R9 close"); chk(dq_oe, 1'b0, "R9 closed");
      // R6 early write and R10 strobe
      cyc(0,1,1,0, "R6 row");
      cyc(0,1,0,0, "R6 we");
      cyc(0,0,0,0, "R6 fall"); chk(wr_strobe, 1'b1, "R10 early write strobe");
      chk(dq_oe, 1'b0, "R6 off");
      cyc(0,0,1,0, "R6 we up"); chk(dq_oe, 1'b0, "R6 stays off");
      chk(wr_strobe, 1'b0, "R10 single pulse");
      cyc(0,1,1,0, "R6 rise"); chk(dq_oe, 1'b0, "R6 off at rise");
      // R10 late write and simultaneous fall
      cyc(0,0,1,0, "R10 read");
      cyc(0,0,0,0, "R10 we fall"); chk(wr_strobe, 1'b1, "R10 late write strobe");
      cyc(0,0,0,0, "R10 hold"); chk(wr_strobe, 1'b0, "R10 one clock");
      cyc(0,1,1,0, "R10 rise");
      cyc(0,0,0,0, "R10 both"); chk(wr_strobe, 1'b1, "R10 same-sample fall");
      // R12 refresh ordering
      cyc(1,1,1,1, "R12 close");
      cyc(1,0,1,0, "R12 cas first"); chk(dq_oe, 1'b0, "R12 no drive");
      cyc(0,0,1,0, "R12 row low"); chk(dq_oe, 1'b0, "R12 still off");
      cyc(1,1,1,1, "R12 end");

      // constrained random: each strobe toggles with modest probability
      for (int i = 0; i < 4000; i++) begin
         bit r, c, w, o;
         r = ($urandom % 16 == 0) ? ~ras_n : ras_n;
         c = ($urandom % 4  == 0) ? ~cas_n : cas_n;
         w = ($urandom % 6  == 0) ? ~we_n  : we_n;
         o = ($urandom % 3  == 0) ? ~oe_n  : oe_n;
         cyc(r, c, w, o, "random R2/R10");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(TCK * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule